// File: doc/BRIEF.md
# Symmetric Glitch-Rejecting Command Filter

This block cleans up a bank of gate command bits before they reach the power stage drivers. Each command line is first brought into the local clock domain by a short flip-flop chain. It then passes a qualifier that accepts a new level only after that level has been seen on every clock edge for a programmable number of cycles. Spikes of either polarity shorter than the qualification time are discarded. A counter that restarts whenever the line falls back to the accepted level makes sure that short spikes never add up.

Rising and falling transitions go through the same synchronizer and the same qualification count, so both edges are delayed by the same amount. An accepted pulse therefore leaves the block with the same width it entered with. A filter that delays one edge and not the other would shorten every pulse by the filter time. Each channel is independent. The output rests high, which is the inactive (off) level for commands that act when low. The qualification time is set in clock cycles. At a 100 MHz clock, a value of 45 gives roughly 450 ns, so commands of 500 ns or more pass reliably.

Top module: `glitch_filter_bank`

## Requirements
- R1: While rst_n is low, every bit of cmd_o is 1 (inactive), whatever cmd_i is. The output stays at 1 after reset is released until a low level on cmd_i has been qualified.
- R2: When a channel output is 0, a high pulse on its input that lasts fewer than FILT_CYCLES clock cycles leaves the output at 0.
- R3: When a channel output is 1, a low pulse on its input that lasts fewer than FILT_CYCLES clock cycles leaves the output at 1.
- R4: An input level held for at least FILT_CYCLES cycles appears on the output exactly SYNC_STAGES + FILT_CYCLES clock cycles after it is applied. The delay is the same for rising and falling changes.
- R5: An input pulse of W cycles, with W >= FILT_CYCLES, gives an output pulse of exactly W cycles for both polarities.
- R6: Sub-threshold pulses do not accumulate. A train of pulses, each FILT_CYCLES-1 cycles long and each separated from the next by one cycle of the accepted level, never changes the output.
- R7: Channels are independent. A stimulus on some bits of cmd_i leaves the other bits of cmd_o at their settled level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| cmd_i | input | CHANNELS | Raw command bits, asynchronous to clk |
| cmd_o | output | CHANNELS | Filtered command bits, reset level 1 |

## Verification
The bench builds the block with six channels, FILT_CYCLES = 5 and SYNC_STAGES = 2. The qualification boundary is then short enough to probe directly: pulses of 1 and 4 cycles are rejected and pulses of 5 cycles pass. The total latency of 7 cycles can be measured edge by edge, and long 13- and 20-cycle pulses stay cheap to run. Partial channel masks show whether one channel disturbs another. A comb of 4-cycle glitches tests whether the counter restarts between glitches.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Level a filtered command takes after reset: high means the driver is off.
  localparam logic REST_LEVEL = 1'b1;

  // Bits needed to count from 0 up to n-1 (never fewer than one).
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/gf_rst_sync.sv
module gf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] chain_q;

  // Asserts at once, releases two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= {chain_q[0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[1];

endmodule

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RESET_VAL;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RESET_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gf_qual.sv
module gf_qual
  import gf_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 45,
  parameter logic        RESET_VAL   = REST_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic filt_o
);

  localparam int unsigned CW   = cnt_bits(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differs, done, upd;

  // A differing level is counted on each edge; the FILT_CYCLES-th such edge
  // takes it. Any edge where input equals output clears the count.
  always_comb begin
    differs = sync_i ^ out_q;
    done    = differs && (cnt_q == LAST);
    out_d   = out_q;
    cnt_d   = '0;
    if (done) begin
      out_d = sync_i;
    end else if (differs) begin
      cnt_d = cnt_q + 1'b1;
    end
    upd = differs || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RESET_VAL;
      cnt_q <= '0;
    end else if (upd) begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign filt_o = out_q;

  // R4: the count never reaches the qualification length.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4: a new output level is always the level the synchronizer presented.
  assert_flip_to_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> (out_q == $past(sync_i)));

  // R2: an input matching the output never moves the output.
  assert_hold_when_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i == out_q) |=> $stable(out_q));

  if (FILT_CYCLES >= 2) begin : g_multi
    // R6: the output only moves after at least two agreeing input samples.
    assert_stable_before_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q != $past(out_q)) |-> ($past(sync_i) == $past(sync_i, 2)));
  end

endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
  import gf_pkg::*;
#(
  parameter int unsigned CHANNELS    = 6,
  parameter int unsigned FILT_CYCLES = 45,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] cmd_i,
  output logic [CHANNELS-1:0] cmd_o
);

  logic                rst_n_int;
  logic [CHANNELS-1:0] cmd_sync;

  gf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    gf_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (REST_LEVEL)
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .async_i (cmd_i[c]),
      .sync_o  (cmd_sync[c])
    );

    gf_qual #(
      .FILT_CYCLES (FILT_CYCLES),
      .RESET_VAL   (REST_LEVEL)
    ) u_qual (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .sync_i (cmd_sync[c]),
      .filt_o (cmd_o[c])
    );
  end

endmodule

// File: tb/tb_glitch_filter_bank.sv
module tb_glitch_filter_bank;

  localparam int CH     = 6;
  localparam int FILT   = 5;
  localparam int SYNC   = 2;
  localparam int LAT    = SYNC + FILT;
  localparam int SETTLE = LAT + FILT + 3;

  typedef struct packed {
    logic       base;
    logic [5:0] mask;
    logic [7:0] width;
    logic       pass;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 6'h3F, 8'd1,  1'b0},
    '{1'b1, 6'h01, 8'd4,  1'b0},
    '{1'b1, 6'h01, 8'd5,  1'b1},
    '{1'b1, 6'h2A, 8'd20, 1'b1},
    '{1'b0, 6'h3F, 8'd4,  1'b0},
    '{1'b0, 6'h10, 8'd5,  1'b1},
    '{1'b0, 6'h15, 8'd13, 1'b1},
    '{1'b0, 6'h3F, 8'd1,  1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic [CH-1:0] cmd_i;
  logic [CH-1:0] cmd_o;

  int n_checks = 0;
  int n_fail   = 0;

  glitch_filter_bank #(
    .CHANNELS    (CH),
    .FILT_CYCLES (FILT),
    .SYNC_STAGES (SYNC)
  ) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (cmd_i),
    .cmd_o (cmd_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_pulse(input logic base, input logic [5:0] mask,
                           input int width, input logic pass);
    int first [CH];
    int hits  [CH];
    int stray;
    string tg;
    cmd_i = {CH{base}};
    repeat (SETTLE) @(negedge clk);
    check(cmd_o == {CH{base}}, "R4 settle", int'(cmd_o), int'({CH{base}}));
    for (int c = 0; c < CH; c++) begin
      first[c] = -1;
      hits[c]  = 0;
    end
    stray = 0;
    cmd_i = {CH{base}} ^ mask;
    for (int n = 1; n <= width + LAT + 6; n++) begin
      @(negedge clk);
      for (int c = 0; c < CH; c++) begin
        if (cmd_o[c] != base) begin
          if (mask[c]) begin
            if (first[c] < 0) first[c] = n;
            hits[c]++;
          end else begin
            stray++;
          end
        end
      end
      if (n == width) cmd_i = {CH{base}};
    end
    tg = pass ? "R5 width" : (base ? "R3 reject" : "R2 reject");
    for (int c = 0; c < CH; c++) begin
      if (mask[c]) begin
        check(hits[c] == (pass ? width : 0), tg, hits[c], pass ? width : 0);
        if (pass) check(first[c] == LAT, "R4 latency", first[c], LAT);
      end
    end
    check(stray == 0, "R7 isolation", stray, 0);
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_i = '0;
    #23;
    check(cmd_o == 6'h3F, "R1 in reset", int'(cmd_o), 63);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_o == 6'h3F, "R1 after release", int'(cmd_o), 63);

    for (int v = 0; v < 8; v++) begin
      run_pulse(VECS[v].base, VECS[v].mask, int'(VECS[v].width), VECS[v].pass);
    end

    // R6: comb of 4-cycle low glitches with 1-cycle high gaps
    begin
      int moved;
      moved = 0;
      cmd_i = '1;
      repeat (SETTLE) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
        cmd_i = '0;
        for (int j = 0; j < FILT - 1; j++) begin
          @(negedge clk);
          if (cmd_o != 6'h3F) moved++;
        end
        cmd_i = '1;
        @(negedge clk);
        if (cmd_o != 6'h3F) moved++;
      end
      for (int j = 0; j < LAT + 2; j++) begin
        @(negedge clk);
        if (cmd_o != 6'h3F) moved++;
      end
      check(moved == 0, "R6 no accumulation", moved, 0);
    end

    // R1: reset during operation forces the inactive level at once
    cmd_i = '0;
    repeat (SETTLE) @(negedge clk);
    check(cmd_o == 6'h00, "R4 settle low", int'(cmd_o), 0);
    rst_n = 1'b0;
    #1;
    check(cmd_o == 6'h3F, "R1 async reset", int'(cmd_o), 63);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule